// File: doc/BRIEF.md
# Receive Timestamp Prepender

This block sits on one port's receive stream, between the MAC and the packet parser. When stamping is switched on for the port, it attaches an 8-byte time value to the front of every frame. There is no filtering: either every frame carries the stamp or none does. The time value is the free-running 64-bit time counter, captured when the frame's first byte is taken in. It is sent most significant byte first, so the parser reads it as a big-endian quantity from the first eight bytes of the frame.

The stream is byte wide, with valid/ready handshaking and start and end markers on both sides. While the block sends the stamp, it stops the input. For that time it holds the frame's first byte internally. With stamping off, frames pass through unchanged and with no added latency.

A frame-length limit is checked on the output side. On a stamped frame the limit is raised by the eight stamp bytes. The block also reports the header skip that the parser must apply, counted in 2-byte units. The stamping mode is sampled once per frame, when the frame's first byte is accepted.

Top module: `rx_stamp_prepend`

## Requirements
- R1: With stamping enabled when a frame's first byte is accepted, the output frame is 8 timestamp bytes followed by every input byte in order. The output start marker is on the first timestamp byte and the output end marker is on the last input byte.
- R2: The 8 prepended bytes equal the 64-bit time input sampled on the clock edge that accepts the input start-of-frame byte. Output byte 0 carries bits 63:56 and output byte 7 carries bits 7:0.
- R3: With stamping disabled when a frame's first byte is accepted, the frame passes through byte for byte with unchanged markers and length.
- R4: From the acceptance of a stamped frame's first byte until its held first byte has been sent (output bytes 0 to 8), the input ready is low.
- R5: A change of the enable during a frame has no effect on that frame. The mode applies only from the next accepted start-of-frame byte.
- R6: The length-error output is high on a frame's end beat if and only if the output frame length exceeds the length limit. The length counts the stamp bytes. The limit is the configured maximum plus 8 for a stamped frame, or the configured maximum for an unstamped one.
- R7: From the clock edge after a frame's first byte is accepted, the header-skip output reads 4 (2-byte units) for a stamped frame and 0 for an unstamped one.
- R8: While output valid is high and output ready is low, output valid, data and both markers hold their values.
- R9: During and right after reset, output valid, length error and header skip are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 64 | Free-running time counter |
| stampEn | input | 1 | Port stamping enable from the frame-control register |
| maxLen | input | 16 | Configured maximum frame length in bytes |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted |
| inData | input | 8 | Input byte |
| inSop | input | 1 | Input first byte of frame |
| inEop | input | 1 | Input last byte of frame |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream ready |
| outData | output | 8 | Output byte |
| outSop | output | 1 | Output first byte of frame |
| outEop | output | 1 | Output last byte of frame |
| outLenErr | output | 1 | Length limit exceeded, on the end beat |
| hdrSkip | output | 3 | Parser header skip in 2-byte units |

## Verification
Frame lengths from one byte to past the length limit are swept with stamping on and with it off. This separates the prepend path from the pass-through path. It also puts the length limit just below, on, and just above the boundary in both modes. The single-byte stamped frame exercises the case where the held first byte is also the last byte. The sweeps are repeated with a pseudo-random output stall pattern and with gaps on the input valid. These show that the stamp holds under backpressure and that it carries the time of the start-byte acceptance, not the time it is emitted. Frames where the enable flips right after the start byte, or in mid-frame, show that the mode is latched per frame.

// File: rtl/rxstamp_pkg.sv
package rxstamp_pkg;
  localparam int STAMP_BYTES = 8;
  localparam int TS_W        = STAMP_BYTES * 8;
  localparam int IDX_W       = $clog2(STAMP_BYTES);
  localparam int SKIP_UNITS  = STAMP_BYTES / 2;
  localparam int SKIP_W      = $clog2(SKIP_UNITS + 1);

  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_TS   = 2'd1,
    SEL_HOLD = 2'd2
  } outSel_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic             capture;      // start byte taken in a stamped frame
    logic             frameStart;   // any start byte taken
    logic             stampNow;     // enable level at frameStart
    logic             stampedFrame; // current output frame carries a stamp
    logic             outFire;      // output handshake this cycle
    outSel_e          outSel;
    logic [IDX_W-1:0] byteIdx;
  } ctlStrb_t;
endpackage

// File: rtl/rxstamp_ctrl.sv
module rxstamp_ctrl
  import rxstamp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stampEn,
  input  logic     inValid,
  input  logic     inSop,
  input  logic     inEop,
  input  logic     outReady,
  input  logic     holdEop,
  output logic     inReady,
  output logic     outValid,
  output logic     outSop,
  output ctlStrb_t strb
);
  typedef enum logic [1:0] {PH_IDLE, PH_STAMP, PH_HELD, PH_BODY} phase_e;

  phase_e           phase, phaseNxt;
  logic [IDX_W-1:0] idx, idxNxt;
  logic             frameStamped;
  logic             inFire, outFire;
  outSel_e          sel;

  always_comb begin
    inReady  = 1'b0;
    outValid = 1'b0;
    outSop   = 1'b0;
    sel      = SEL_PASS;
    phaseNxt = phase;
    idxNxt   = idx;
    case (phase)
      PH_IDLE: begin
        if (stampEn) begin
          inReady = 1'b1;
        end else begin
          outValid = inValid && inSop;
          outSop   = inSop;
          inReady  = inSop ? outReady : 1'b1;
        end
      end
      PH_STAMP: begin
        outValid = 1'b1;
        outSop   = (idx == '0);
        sel      = SEL_TS;
      end
      PH_HELD: begin
        outValid = 1'b1;
        sel      = SEL_HOLD;
      end
      default: begin
        outValid = inValid;
        inReady  = outReady;
      end
    endcase
    inFire  = inValid && inReady;
    outFire = outValid && outReady;
    case (phase)
      PH_IDLE: begin
        if (inFire && inSop) begin
          if (stampEn) begin
            phaseNxt = PH_STAMP;
            idxNxt   = '0;
          end else if (!inEop) begin
            phaseNxt = PH_BODY;
          end
        end
      end
      PH_STAMP: begin
        if (outFire) begin
          if (idx == IDX_W'(STAMP_BYTES - 1)) phaseNxt = PH_HELD;
          else                                idxNxt   = idx + 1'b1;
        end
      end
      PH_HELD: begin
        if (outFire) phaseNxt = holdEop ? PH_IDLE : PH_BODY;
      end
      default: begin
        if (inFire && inEop) phaseNxt = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      idx          <= '0;
      frameStamped <= 1'b0;
    end else begin
      phase <= phaseNxt;
      idx   <= idxNxt;
      if (phase == PH_IDLE && inFire && inSop) frameStamped <= stampEn;
    end
  end

  always_comb begin
    strb.frameStart   = (phase == PH_IDLE) && inFire && inSop;
    strb.capture      = strb.frameStart && stampEn;
    strb.stampNow     = stampEn;
    strb.stampedFrame = (phase != PH_IDLE) && frameStamped;
    strb.outFire      = outFire;
    strb.outSel       = sel;
    strb.byteIdx      = idx;
  end

  // R4
  stall_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STAMP || phase == PH_HELD) |-> !inReady);

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STAMP && !outReady) |=> (phase == PH_STAMP) && $stable(idx));
endmodule

// File: rtl/rxstamp_dp.sv
module rxstamp_dp
  import rxstamp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [TS_W-1:0]   timeNow,
  input  logic [7:0]        inData,
  input  logic              inEop,
  input  logic              outValid,
  input  logic [LEN_W-1:0]  maxLen,
  output logic [7:0]        outData,
  output logic              outEop,
  output logic              outLenErr,
  output logic              holdEop,
  output logic [SKIP_W-1:0] hdrSkip
);
  localparam logic [LEN_W:0] EXTRA = (LEN_W+1)'(STAMP_BYTES);

  logic [TS_W-1:0]  tsHold, tsShift;
  logic [7:0]       holdByte;
  logic             holdEopQ;
  logic [LEN_W-1:0] byteCnt;
  logic [LEN_W:0]   limit, frameLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsHold   <= '0;
      holdByte <= '0;
      holdEopQ <= 1'b0;
      byteCnt  <= '0;
      hdrSkip  <= '0;
    end else begin
      if (strb.capture) begin
        tsHold   <= timeNow;
        holdByte <= inData;
        holdEopQ <= inEop;
      end
      if (strb.frameStart)
        hdrSkip <= strb.stampNow ? SKIP_W'(SKIP_UNITS) : '0;
      if (strb.outFire) begin
        if (outEop)              byteCnt <= '0;
        else if (byteCnt != '1)  byteCnt <= byteCnt + 1'b1;
      end
    end
  end

  assign tsShift = tsHold << (8 * strb.byteIdx);

  always_comb begin
    case (strb.outSel)
      SEL_TS: begin
        outData = tsShift[TS_W-1 -: 8];
        outEop  = 1'b0;
      end
      SEL_HOLD: begin
        outData = holdByte;
        outEop  = holdEopQ;
      end
      default: begin
        outData = inData;
        outEop  = inEop;
      end
    endcase
  end

  assign limit     = {1'b0, maxLen} + (strb.stampedFrame ? EXTRA : '0);
  assign frameLen  = {1'b0, byteCnt} + 1'b1;
  assign outLenErr = outValid && outEop && (frameLen > limit);
  assign holdEop   = holdEopQ;

  // R2
  ts_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.outSel == SEL_TS && strb.byteIdx != '0) |-> $stable(tsHold));
endmodule

// File: rtl/rx_stamp_prepend.sv
module rx_stamp_prepend
  import rxstamp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TS_W-1:0]   timeNow,
  input  logic              stampEn,
  input  logic [LEN_W-1:0]  maxLen,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outSop,
  output logic              outEop,
  output logic              outLenErr,
  output logic [SKIP_W-1:0] hdrSkip
);
  ctlStrb_t strb;
  logic     holdEop;

  rxstamp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stampEn(stampEn),
    .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .outReady(outReady), .holdEop(holdEop),
    .inReady(inReady), .outValid(outValid), .outSop(outSop), .strb(strb)
  );

  rxstamp_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timeNow(timeNow),
    .inData(inData), .inEop(inEop), .outValid(outValid), .maxLen(maxLen),
    .outData(outData), .outEop(outEop), .outLenErr(outLenErr),
    .holdEop(holdEop), .hdrSkip(hdrSkip)
  );

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData) && $stable(outSop) && $stable(outEop));

  // R6
  len_err_eop_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLenErr |-> (outValid && outEop));
endmodule

// File: tb/test_rx_stamp_prepend.sv
module test_rx_stamp_prepend;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] timeNow;
  logic        stampEn;
  logic [15:0] maxLen;
  logic        inValid, inReady, inSop, inEop;
  logic [7:0]  inData;
  logic        outValid, outReady, outSop, outEop, outLenErr;
  logic [7:0]  outData;
  logic [2:0]  hdrSkip;

  always #10 clk = ~clk;

  rx_stamp_prepend i_rx_stamp_prepend (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .stampEn(stampEn), .maxLen(maxLen),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inSop(inSop), .inEop(inEop),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSop(outSop),
    .outEop(outEop), .outLenErr(outLenErr), .hdrSkip(hdrSkip)
  );

  integer nChecks = 0, nFails = 0;
  bit     finished = 0;
  bit     stallMode = 0;
  logic [7:0] lfsr = 8'hA5;
  string  frameTag = "";

  logic [7:0] expBuf [0:63];
  logic [7:0] gotBuf [0:63];
  int  expLen = 0, inLen = 0, gotLen = 0, framesDone = 0;
  bit  expStamped = 0, skipPending = 0, r4Bad = 0, sopBad = 0, stallPrev = 0;
  logic [7:0] stallData;
  logic stallSop, stallEop;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    timeNow = timeNow + 64'h0102_0304_0506_0709;
    lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = stallMode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (skipPending) begin
        // R7
        check(hdrSkip == (expStamped ? 3'd4 : 3'd0), "R7", "header skip", 64'(hdrSkip),
              expStamped ? 64'd4 : 64'd0);
        skipPending = 0;
      end
      if (stallPrev) begin
        // R8
        check(outValid && outData == stallData && outSop == stallSop && outEop == stallEop,
              "R8", "held output beat", {outValid, outSop, outEop, outData},
              {1'b1, stallSop, stallEop, stallData});
      end
      stallPrev = outValid && !outReady;
      stallData = outData; stallSop = outSop; stallEop = outEop;
      if (expStamped && outValid && gotLen < 9 && inReady) r4Bad = 1;

      if (inValid && inReady) begin
        if (inSop) begin
          expLen = 0; inLen = 0; expStamped = stampEn; r4Bad = 0; skipPending = 1;
          if (stampEn)
            for (int k = 0; k < 8; k++) begin
              expBuf[expLen] = timeNow[63-8*k -: 8];
              expLen++;
            end
        end
        expBuf[expLen] = inData;
        expLen++; inLen++;
      end

      if (outValid && outReady) begin
        if ((gotLen == 0) != outSop) sopBad = 1;
        gotBuf[gotLen] = outData;
        gotLen++;
        if (outEop) begin
          begin
            int bad = -1;
            string req;
            for (int k = 0; k < gotLen && k < expLen; k++)
              if (bad < 0 && gotBuf[k] != expBuf[k]) bad = k;
            req = (frameTag != "") ? frameTag : (expStamped ? "R1" : "R3");
            if (expStamped) begin
              // R2: stamp bytes versus time at start-byte acceptance
              check(bad < 0 || bad > 7, "R2", $sformatf("stamp byte %0d", bad),
                    bad >= 0 ? 64'(gotBuf[bad]) : 0, bad >= 0 ? 64'(expBuf[bad]) : 0);
              // R4
              check(!r4Bad, "R4", "input ready during stamp", 64'(r4Bad), 0);
            end
            check(bad < 0 && gotLen == expLen && !sopBad, req,
                  $sformatf("frame len %0d mismatch at %0d", inLen, bad),
                  bad >= 0 ? 64'(gotBuf[bad]) : 64'(gotLen),
                  bad >= 0 ? 64'(expBuf[bad]) : 64'(expLen));
            // R6
            check(outLenErr == (inLen > int'(maxLen)), "R6",
                  $sformatf("length error, len %0d max %0d", inLen, maxLen),
                  64'(outLenErr), 64'(inLen > int'(maxLen)));
          end
          gotLen = 0; sopBad = 0; framesDone++;
        end
      end
    end
  end

  task automatic sendFrame(input int len, input bit en, input int flipAt);
    int target = framesDone + 1;
    stampEn = en;
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = 8'(i * 37 + len * 5 + (en ? 3 : 0));
      inSop   = (i == 0);
      inEop   = (i == len - 1);
      @(negedge clk);
      while (!inReady) @(negedge clk);
      @(posedge clk); #2;
      if (i == flipAt) stampEn = !en;  // R5: mid-frame flip
      if (i % 3 == 2) begin
        inValid = 1'b0;
        @(posedge clk); #2;
      end
    end
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    while (framesDone < target) begin
      @(posedge clk); #2;
    end
    @(posedge clk); #2;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rstN = 1'b0; timeNow = 64'h1122_3344_5566_7788; stampEn = 1'b0; maxLen = 16'd10;
    inValid = 1'b0; inData = '0; inSop = 1'b0; inEop = 1'b0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9
    check(!outValid && !outLenErr && hdrSkip == 0, "R9", "reset outputs",
          {outValid, outLenErr, hdrSkip}, 0);
    @(posedge clk); #2; rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !outLenErr && hdrSkip == 0, "R9", "after reset",
          {outValid, outLenErr, hdrSkip}, 0);
    @(posedge clk); #2;

    for (int s = 0; s < 2; s++) begin
      stallMode = (s == 1);
      for (int len = 1; len <= 12; len++)
        for (int en = 0; en < 2; en++)
          sendFrame(len, en[0], -1);
    end

    frameTag = "R5";
    sendFrame(6, 1'b1, 0);
    sendFrame(6, 1'b0, 0);
    sendFrame(7, 1'b1, 3);
    sendFrame(1, 1'b0, 0);
    frameTag = "";

    maxLen = 16'd3;
    for (int len = 2; len <= 4; len++)
      for (int en = 0; en < 2; en++)
        sendFrame(len, en[0], -1);

    repeat (5) @(posedge clk);
    summary();
  end
endmodule